// File: doc/BRIEF.md
# Banked Frequency Configuration Register File

This block stores the divider settings that steer a fractional-N clock synthesizer. It keeps four complete configuration banks. Each bank holds a 2-bit pre-divider, a 7-bit integer feedback value, an 18-bit fractional feedback value and a 7-bit post-divider. One tuning register is shared by all banks and holds a 6-bit gain and a 1-bit polarity. A two-bit select input, brought in from pins through a synchronizer, picks the bank that drives the synthesizer outputs. The switch happens without any handshake.

A byte-wide register port stands in for a serial-bus slave. It writes and reads every bank, including the one in use. A bank is written as five bytes. The first four bytes collect in a staging register, and the fifth byte commits all 34 bits at once. The synthesizer therefore never sees a half-written bank. Reset reloads every bank and the tuning register from parameterised factory defaults. A one-cycle `cfgChanged` pulse marks each cycle in which the active configuration changes.

Top module: `freq_cfg_bank`

## Requirements
- R1: Bank `b` occupies addresses `{3'b000, b[1:0], k[2:0]}` with byte index k in 0..4. The 34-bit bank word is `{P[1:0], MINT[6:0], MFRAC[17:0], N[6:0]}`, with N in bits 6:0. Byte k holds word bits 8k+7..8k, and byte 4 holds P in bits 1:0 with zeros above.
- R2: After reset every bank and the tuning register hold their default values, bank 0 drives the outputs, and `cfgChanged` is low.
- R3: Once synchronized, select value 0, 1, 2 or 3 drives bank 0, 1, 2 or 3 onto `preDiv`, `fbInt`, `fbFrac` and `postDiv`.
- R4: `selPin` passes through two flops. The outputs still show the old bank after the first rising edge following a change and show the new bank after the second.
- R5: Writes to bytes 0 to 3 only stage data. A bank's stored contents change only at the edge where its byte 4 is written. That write loads the four staged bytes and bits 1:0 of the written data together.
- R6: `regRdData` returns the committed byte at the current address in the same cycle, and never the staged data. Bits 7:2 of byte 4 read as zero.
- R7: Address 0x20 is the shared tuning register, with gain in bits 5:0 and polarity in bit 6. A write takes effect on `tuneGain` and `tunePol` at the next edge whatever the select value, and a read returns `{1'b0, pol, gain}`.
- R8: `cfgChanged` is high for exactly the one cycle in which the outputs first show a newly synchronized select value.
- R9: A commit that alters the active bank raises `cfgChanged` in the cycle its new value first appears. A commit to an inactive bank, a staging write or a tuning write leaves `cfgChanged` low and the divider outputs unchanged.
- R10: Writes to unmapped addresses (byte index 5 to 7, or any address above 0x20) change no bank, no tuning bit and no staged data, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, reloads defaults |
| selPin | input | 2 | Asynchronous bank select |
| regAddr | input | 8 | Register port address |
| regWrEn | input | 1 | Write strobe for one byte |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational readback at regAddr |
| preDiv | output | 2 | Active bank pre-divider |
| fbInt | output | 7 | Active bank integer feedback |
| fbFrac | output | 18 | Active bank fractional feedback |
| postDiv | output | 7 | Active bank post-divider |
| tuneGain | output | 6 | Shared gain |
| tunePol | output | 1 | Shared polarity |
| cfgChanged | output | 1 | One-cycle pulse on an active configuration change |

## Verification
The bench steps the select through all four values. It samples one edge and two edges after each change, which separates correct synchronizer depth from a short path or a long one. A bank write is interleaved with the select so that staging-only traffic, a commit to the active bank and a commit to an idle bank are each observed. These three cases separate a correct commit point and a correctly gated pulse from early application or a spurious pulse. Unmapped writes are followed by a full readback of the banks and the tuning register, and a following commit exposes any corruption of the staged data.

// File: rtl/freq_cfg_pkg.sv
package freq_cfg_pkg;
  localparam int P_W      = 2;
  localparam int MINT_W   = 7;
  localparam int MFRAC_W  = 18;
  localparam int N_W      = 7;
  localparam int SET_W    = P_W + MINT_W + MFRAC_W + N_W;
  localparam int NUM_SETS = 4;
  localparam int SEL_W    = $clog2(NUM_SETS);
  localparam int GAIN_W   = 6;
  localparam int TUNE_W   = GAIN_W + 1;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 8;

  localparam int BYTES_PER_SET = (SET_W + DATA_W - 1) / DATA_W;
  localparam int BYTE_IDX_W    = $clog2(BYTES_PER_SET);
  localparam int STAGE_BYTES   = BYTES_PER_SET - 1;
  localparam int STAGE_W       = STAGE_BYTES * DATA_W;
  localparam int LAST_W        = SET_W - STAGE_W;
  localparam int PAD_W         = BYTES_PER_SET * DATA_W - SET_W;
  localparam int TUNE_ADDR     = NUM_SETS << BYTE_IDX_W;

  localparam int N_LSB    = 0;
  localparam int FRAC_LSB = N_LSB + N_W;
  localparam int MINT_LSB = FRAC_LSB + MFRAC_W;
  localparam int P_LSB    = MINT_LSB + MINT_W;

  typedef struct packed {
    logic [STAGE_BYTES-1:0] stageWe;
    logic                   commitWe;
    logic                   tuneWe;
    logic [SEL_W-1:0]       tgtSet;
    logic [BYTE_IDX_W-1:0]  byteIdx;
    logic                   setHit;
    logic                   tuneHit;
  } cfg_strb_t;
endpackage

// File: rtl/freq_cfg_ctrl.sv
module freq_cfg_ctrl
  import freq_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  selPin,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output logic [SEL_W-1:0]  selSync,
  output cfg_strb_t         strb
);
  localparam int AREA_LSB = SEL_W + BYTE_IDX_W;

  logic [SEL_W-1:0]      selMeta;
  logic [BYTE_IDX_W-1:0] byteIdx;
  logic                  setArea;
  logic                  setHit;

  // two-flop synchronizer on the asynchronous select pins
  always_ff @(posedge clk) begin
    if (rst) begin
      selMeta <= '0;
      selSync <= '0;
    end else begin
      selMeta <= selPin;
      selSync <= selMeta;
    end
  end

  assign byteIdx = regAddr[BYTE_IDX_W-1:0];
  assign setArea = (regAddr[ADDR_W-1:AREA_LSB] == '0);
  assign setHit  = setArea && (byteIdx < BYTE_IDX_W'(BYTES_PER_SET));

  for (genvar k = 0; k < STAGE_BYTES; k++) begin : g_stage
    assign strb.stageWe[k] = regWrEn && setHit && (byteIdx == BYTE_IDX_W'(k));
  end

  assign strb.commitWe = regWrEn && setHit && (byteIdx == BYTE_IDX_W'(BYTES_PER_SET - 1));
  assign strb.tuneHit  = (regAddr == ADDR_W'(TUNE_ADDR));
  assign strb.tuneWe   = regWrEn && strb.tuneHit;
  assign strb.tgtSet   = regAddr[AREA_LSB-1:BYTE_IDX_W];
  assign strb.byteIdx  = byteIdx;
  assign strb.setHit   = setHit;

  // at most one storage action per write (R5, R7, R10)
  p_one_action_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.stageWe, strb.commitWe, strb.tuneWe}));
endmodule

// File: rtl/freq_cfg_dpath.sv
module freq_cfg_dpath
  import freq_cfg_pkg::*;
#(
  parameter logic [NUM_SETS*SET_W-1:0] DEF_SETS = '0,
  parameter logic [TUNE_W-1:0]         DEF_TUNE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  selSync,
  input  cfg_strb_t         strb,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [SET_W-1:0]  activeVec,
  output logic [TUNE_W-1:0] tuneVal,
  output logic              cfgChanged
);
  logic [SET_W-1:0]   setReg [NUM_SETS];
  logic [STAGE_W-1:0] stageReg;
  logic [TUNE_W-1:0]  tuneReg;
  logic [SEL_W-1:0]   selPrev;
  logic [SET_W-1:0]   activePrev;
  logic [BYTES_PER_SET*DATA_W-1:0] rdVec;

  for (genvar k = 0; k < STAGE_BYTES; k++) begin : g_stg
    always_ff @(posedge clk) begin
      if (rst)                  stageReg[k*DATA_W +: DATA_W] <= '0;
      else if (strb.stageWe[k]) stageReg[k*DATA_W +: DATA_W] <= regWrData;
    end
  end

  for (genvar i = 0; i < NUM_SETS; i++) begin : g_set
    always_ff @(posedge clk) begin
      if (rst)
        setReg[i] <= DEF_SETS[i*SET_W +: SET_W];
      else if (strb.commitWe && strb.tgtSet == SEL_W'(i))
        setReg[i] <= {regWrData[LAST_W-1:0], stageReg};
    end

    // bank contents move only on their own commit (R5)
    p_bank_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !(strb.commitWe && strb.tgtSet == SEL_W'(i)) |=> $stable(setReg[i]));
  end

  always_ff @(posedge clk) begin
    if (rst)              tuneReg <= DEF_TUNE;
    else if (strb.tuneWe) tuneReg <= regWrData[TUNE_W-1:0];
  end

  assign activeVec = setReg[selSync];
  assign tuneVal   = tuneReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      selPrev    <= '0;
      activePrev <= DEF_SETS[SET_W-1:0];
    end else begin
      selPrev    <= selSync;
      activePrev <= activeVec;
    end
  end

  assign cfgChanged = (selSync != selPrev) || (activeVec != activePrev);

  assign rdVec = {{PAD_W{1'b0}}, setReg[strb.tgtSet]};

  always_comb begin
    if (strb.setHit)       regRdData = rdVec[{strb.byteIdx, 3'b000} +: DATA_W];
    else if (strb.tuneHit) regRdData = {{(DATA_W-TUNE_W){1'b0}}, tuneReg};
    else                   regRdData = '0;
  end

  p_sel_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    (selSync != $past(selSync)) |-> cfgChanged);

  p_quiet_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(strb.commitWe) && selSync == $past(selSync)) |-> !cfgChanged);

  p_tune_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !strb.tuneWe |=> $stable(tuneReg));
endmodule

// File: rtl/freq_cfg_bank.sv
module freq_cfg_bank
  import freq_cfg_pkg::*;
#(
  parameter logic [NUM_SETS*SET_W-1:0] DEF_SETS = {
    {2'd2, 7'd90, 18'h00000, 7'd15},
    {2'd0, 7'd21, 18'h3FFFF, 7'd16},
    {2'd1, 7'd43, 18'h20000, 7'd20},
    {2'd1, 7'd44, 18'h01234, 7'd32}},
  parameter logic [TUNE_W-1:0] DEF_TUNE = {1'b0, 6'd8}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SEL_W-1:0]   selPin,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic [P_W-1:0]     preDiv,
  output logic [MINT_W-1:0]  fbInt,
  output logic [MFRAC_W-1:0] fbFrac,
  output logic [N_W-1:0]     postDiv,
  output logic [GAIN_W-1:0]  tuneGain,
  output logic               tunePol,
  output logic               cfgChanged
);
  logic [SEL_W-1:0]  selSync;
  cfg_strb_t         strb;
  logic [SET_W-1:0]  activeVec;
  logic [TUNE_W-1:0] tuneVal;

  freq_cfg_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .selPin  (selPin),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .selSync (selSync),
    .strb    (strb)
  );

  freq_cfg_dpath #(.DEF_SETS(DEF_SETS), .DEF_TUNE(DEF_TUNE)) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .selSync    (selSync),
    .strb       (strb),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .activeVec  (activeVec),
    .tuneVal    (tuneVal),
    .cfgChanged (cfgChanged)
  );

  assign preDiv   = activeVec[P_LSB    +: P_W];
  assign fbInt    = activeVec[MINT_LSB +: MINT_W];
  assign fbFrac   = activeVec[FRAC_LSB +: MFRAC_W];
  assign postDiv  = activeVec[N_LSB    +: N_W];
  assign tuneGain = tuneVal[GAIN_W-1:0];
  assign tunePol  = tuneVal[GAIN_W];
endmodule

// File: tb/freq_cfg_bank_tb.sv
module freq_cfg_bank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  selPin = 2'd0;
  logic [7:0]  regAddr = 8'd0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = 8'd0;
  logic [7:0]  regRdData;
  logic [1:0]  preDiv;
  logic [6:0]  fbInt;
  logic [17:0] fbFrac;
  logic [6:0]  postDiv;
  logic [5:0]  tuneGain;
  logic        tunePol;
  logic        cfgChanged;

  int checks = 0;
  int fails  = 0;
  logic [33:0] expSet [4];
  logic [6:0]  expTune;
  logic [1:0]  curSel;

  always #2.5 clk = ~clk;

  freq_cfg_bank u_dut (
    .clk(clk), .rst(rst), .selPin(selPin), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .preDiv(preDiv), .fbInt(fbInt), .fbFrac(fbFrac), .postDiv(postDiv),
    .tuneGain(tuneGain), .tunePol(tunePol), .cfgChanged(cfgChanged));

  function automatic logic [33:0] mk(input logic [1:0] p, input logic [6:0] mi,
                                     input logic [17:0] mf, input logic [6:0] n);
    return {p, mi, mf, n};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkOut(input logic [33:0] exp, input string tag);
    logic [33:0] act;
    act = {preDiv, fbInt, fbFrac, postDiv};
    chk(act == exp, tag, 64'(act), 64'(exp));
  endtask

  task automatic wrByte(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdByte(input logic [7:0] a, output logic [7:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  task automatic stageSet(input logic [1:0] s, input logic [33:0] v);
    for (int k = 0; k < 4; k++) wrByte({3'b000, s, 3'(k)}, v[8*k +: 8]);
  endtask

  task automatic chkReadSet(input logic [1:0] s, input string tag);
    logic [7:0] d;
    logic [39:0] ev;
    ev = {6'b0, expSet[s]};
    for (int k = 0; k < 5; k++) begin
      rdByte({3'b000, s, 3'(k)}, d);
      chk(d == ev[8*k +: 8], tag, 64'(d), 64'(ev[8*k +: 8]));
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chkOut(expSet[0], "R2 reset bank0 active");
    chk(cfgChanged == 1'b0, "R2 no pulse after reset", 64'(cfgChanged), 64'd0);
    chk({tunePol, tuneGain} == expTune, "R2 tune default", 64'({tunePol, tuneGain}), 64'(expTune));
    for (int s = 0; s < 4; s++) chkReadSet(2'(s), "R2 R6 R1 default readback");
    rdByte(8'h20, d);
    chk(d == {1'b0, expTune}, "R7 tune readback", 64'(d), 64'({1'b0, expTune}));
    rdByte(8'h04, d);
    chk(d[7:2] == 6'd0, "R6 byte4 upper zero", 64'(d), 64'({6'd0, expSet[0][33:32]}));
  endtask

  task automatic t_select(input logic [1:0] s);
    logic [33:0] old;
    old = expSet[curSel];
    @(negedge clk);
    selPin = s;
    @(negedge clk);
    chkOut(old, "R4 old bank after one edge");
    chk(cfgChanged == 1'b0, "R4 R8 no early pulse", 64'(cfgChanged), 64'd0);
    @(negedge clk);
    chkOut(expSet[s], "R3 R4 new bank after two edges");
    chk(cfgChanged == 1'b1, "R8 pulse on select", 64'(cfgChanged), 64'd1);
    @(negedge clk);
    chk(cfgChanged == 1'b0, "R8 pulse one cycle", 64'(cfgChanged), 64'd0);
    curSel = s;
  endtask

  task automatic t_active_commit;
    logic [33:0] nv;
    nv = mk(2'd3, 7'd55, 18'h2A5A5, 7'd9);
    stageSet(curSel, nv);
    chkOut(expSet[curSel], "R5 staging not applied");
    chk(cfgChanged == 1'b0, "R9 no pulse on staging", 64'(cfgChanged), 64'd0);
    chkReadSet(curSel, "R5 R6 readback shows committed only");
    wrByte({3'b000, curSel, 3'd4}, {6'b101010, nv[33:32]});
    expSet[curSel] = nv;
    chkOut(nv, "R5 commit applies whole bank");
    chk(cfgChanged == 1'b1, "R9 pulse on active commit", 64'(cfgChanged), 64'd1);
    @(negedge clk);
    chk(cfgChanged == 1'b0, "R9 pulse ends", 64'(cfgChanged), 64'd0);
    chkReadSet(curSel, "R1 R6 readback after commit");
  endtask

  task automatic t_idle_commit;
    logic [1:0] s;
    logic [33:0] nv;
    s = curSel + 2'd1;
    nv = mk(2'd0, 7'd100, 18'h15555, 7'd126);
    stageSet(s, nv);
    wrByte({3'b000, s, 3'd4}, {6'd0, nv[33:32]});
    expSet[s] = nv;
    chkOut(expSet[curSel], "R9 idle commit leaves outputs");
    chk(cfgChanged == 1'b0, "R9 no pulse idle commit", 64'(cfgChanged), 64'd0);
    chkReadSet(s, "R6 idle bank readback");
  endtask

  task automatic t_tune;
    logic [7:0] d;
    wrByte(8'h20, 8'hFF);
    expTune = 7'h7F;
    chk({tunePol, tuneGain} == expTune, "R7 tune write", 64'({tunePol, tuneGain}), 64'(expTune));
    chk(cfgChanged == 1'b0, "R9 no pulse on tune", 64'(cfgChanged), 64'd0);
    chkOut(expSet[curSel], "R7 dividers untouched by tune");
    rdByte(8'h20, d);
    chk(d == 8'h7F, "R7 tune readback", 64'(d), 64'h7F);
    wrByte(8'h20, 8'h45);
    expTune = 7'h45;
    chk({tunePol, tuneGain} == expTune, "R7 tune pol gain split", 64'({tunePol, tuneGain}), 64'(expTune));
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    logic [33:0] nv;
    nv = mk(2'd1, 7'd7, 18'h00F0F, 7'd3);
    stageSet(2'd3, nv);
    wrByte(8'h05, 8'hAA);
    wrByte(8'h1F, 8'hAA);
    wrByte(8'h21, 8'hAA);
    wrByte(8'h80, 8'hAA);
    for (int s = 0; s < 4; s++) chkReadSet(2'(s), "R10 banks untouched");
    chk({tunePol, tuneGain} == expTune, "R10 tune untouched", 64'({tunePol, tuneGain}), 64'(expTune));
    rdByte(8'h05, d);
    chk(d == 8'd0, "R10 unmapped read zero", 64'(d), 64'd0);
    rdByte(8'h40, d);
    chk(d == 8'd0, "R10 high unmapped read zero", 64'(d), 64'd0);
    wrByte(8'h1C, {6'd0, nv[33:32]});
    expSet[3] = nv;
    chkReadSet(2'd3, "R10 R5 staged data intact");
  endtask

  initial begin
    expSet[0] = mk(2'd1, 7'd44, 18'h01234, 7'd32);
    expSet[1] = mk(2'd1, 7'd43, 18'h20000, 7'd20);
    expSet[2] = mk(2'd0, 7'd21, 18'h3FFFF, 7'd16);
    expSet[3] = mk(2'd2, 7'd90, 18'h00000, 7'd15);
    expTune = {1'b0, 6'd8};
    curSel = 2'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_select(2'd1);
    t_select(2'd2);
    t_select(2'd3);
    t_select(2'd0);
    t_select(2'd2);
    t_active_commit;
    t_idle_commit;
    t_tune;
    t_unmapped;
    t_select(2'd3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule